// File: doc/BRIEF.md
# Decimal Matrix Code Read-Path Decoder

This block sits on the read side of a memory that holds words protected by a decimal matrix code. Each stored word carries 32 data bits arranged as eight 4-bit symbols in a 2 x 4 grid. For every pair of symbols in a row it also stores a 5-bit integer sum. For every bit column it stores the XOR of the two grid rows. The decoder takes one stored codeword per strobe. It rebuilds the check fields by passing the received data bits through the same encoder logic used on the write side, and compares them with the stored fields. Integer subtraction gives the horizontal syndromes and XOR gives the vertical syndrome.

A pair whose horizontal difference is non-zero is suspect. The vertical syndrome bits then pick out the exact columns, and each data bit that lies in a suspect pair and in a flagged column is inverted. Any upset of up to five adjacent cells, anywhere in the 68-bit word, therefore comes back as the original data. A swap that keeps the pair sum unchanged escapes horizontal location and is passed on uncorrected. This is an accepted limitation of the code.

The result is registered. Corrected data, a detection flag and a correction flag appear one clock after the strobe.

Top module: `dmc_decoder`

## Requirements
- R1: `data_valid_o` is high in exactly the cycle after each cycle in which `cw_valid_i` is sampled high, and low otherwise.
- R2: While `rst_n` is sampled low at a rising edge, the next cycle shows `data_valid_o`, `data_o`, `err_detected_o` and `err_corrected_o` all at zero, whatever the other inputs do.
- R3: A codeword whose check fields match its data returns the data bits unchanged, with both flags low.
- R4: Codeword layout. Bits [31:0] hold data, and symbol s is bits [4s+3:4s]. Bits [51:32] hold four 5-bit horizontal sums, field p at [32+5p+4:32+5p], for the symbol pairs p0=(s0,s2), p1=(s1,s3), p2=(s4,s6) and p3=(s5,s7). Bits [67:52] hold the vertical checks, with bit j equal to data[j] XOR data[j+16].
- R5: The horizontal syndrome of a pair is the recomputed 5-bit sum minus the stored 5-bit sum, modulo 32. A non-zero value marks that pair as holding an error. For example, recomputed 22 against stored 18 marks the pair.
- R6: Data bit n is inverted only when vertical syndrome bit (n mod 16) is set and the pair containing bit n's symbol is marked. If no pair is marked, the data passes unchanged.
- R7: Every burst of 1 to 5 adjacent flipped bits, at any position in the 68-bit codeword, yields the original 32 data bits.
- R8: `err_detected_o` is high when any horizontal or vertical syndrome is non-zero.
- R9: `err_corrected_o` is high exactly when at least one data bit was inverted. Upsets confined to check bits leave the data unchanged, raise `err_detected_o` and keep `err_corrected_o` low.
- R10: Swapping 0110 and 1001 between s0 and s2 leaves pair p0's sum intact. The word is flagged as detected through the vertical syndrome but passes uncorrected, with the swapped data at the output.
- R11: In a cycle with `cw_valid_i` low, `data_o` and both flags hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cw_valid_i | input | 1 | Codeword strobe |
| cw_i | input | 68 | Stored codeword (layout in R4) |
| data_valid_o | output | 1 | Result strobe, one cycle after `cw_valid_i` |
| data_o | output | 32 | Corrected data |
| err_detected_o | output | 1 | Some syndrome was non-zero |
| err_corrected_o | output | 1 | At least one data bit was inverted |

## Verification
The only state in the block is the output register, so a fault in the re-encoder, the subtractors or the flip mask shows in the cycle right after the strobe. It appears as a wrong data word, a wrong flag, or both. It cannot be hidden by a later word. A wrong pair mapping shows up as a miscorrection only when a burst falls in a column shared by two pairs. For this reason, every burst start and every burst length from 1 to 5 is swept over several data patterns, including bursts that straddle the data/check boundary and bursts wholly in the check bits. A hold fault shows up only in the idle cycle after a word, and a dedicated check looks at that cycle.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
// Package dmc_pkg
// Holds the default grid geometry of the decimal matrix code and the index
// helpers that map symbols and data bits onto horizontal pairs.
// Assumes an even number of columns: column c pairs with column c + COLS/2.
package dmc_pkg;

    localparam int unsigned SYM_W = 4;  // bits per symbol
    localparam int unsigned ROWS  = 2;  // grid rows
    localparam int unsigned COLS  = 4;  // symbols per row

    // Index of the first (lower) symbol of horizontal pair p.
    function automatic int unsigned pair_first_sym(input int unsigned p,
                                                   input int unsigned cols);
        return (p / (cols / 2)) * cols + (p % (cols / 2));
    endfunction

    // Horizontal pair that owns data bit n.
    function automatic int unsigned pair_of_bit(input int unsigned n,
                                                input int unsigned sym_w,
                                                input int unsigned cols);
        int unsigned row;
        int unsigned col;
        row = n / (cols * sym_w);
        col = (n % (cols * sym_w)) / sym_w;
        return row * (cols / 2) + (col % (cols / 2));
    endfunction

endpackage

// File: rtl/dmc_encoder.sv
`timescale 1ns/1ps
// Module dmc_encoder
// Combinational check generator. It produces one integer sum per symbol pair
// (SYM_W+1 bits, no overflow) and one XOR across rows per bit column.
// The same logic serves the write path and the decoder's recomputation.
// Assumes COLS is even.
module dmc_encoder #(
    parameter  int unsigned SYM_W  = dmc_pkg::SYM_W,
    parameter  int unsigned ROWS   = dmc_pkg::ROWS,
    parameter  int unsigned COLS   = dmc_pkg::COLS,
    localparam int unsigned DATA_W = SYM_W * ROWS * COLS,
    localparam int unsigned NPAIR  = ROWS * (COLS / 2),
    localparam int unsigned HSUM_W = SYM_W + 1,
    localparam int unsigned VCHK_W = COLS * SYM_W
) (
    input  logic [DATA_W-1:0]       data_i,
    output logic [NPAIR*HSUM_W-1:0] hchk_o,
    output logic [VCHK_W-1:0]       vchk_o
);

    // One adder per pair: the lower symbol plus its partner half a row away.
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int unsigned SA = dmc_pkg::pair_first_sym(p, COLS);
        localparam int unsigned SB = SA + COLS / 2;
        assign hchk_o[p*HSUM_W +: HSUM_W] =
            HSUM_W'(data_i[SA*SYM_W +: SYM_W]) + HSUM_W'(data_i[SB*SYM_W +: SYM_W]);
    end

    // Column parity: XOR of every grid row for each bit column.
    always_comb begin
        vchk_o = '0;
        for (int unsigned r = 0; r < ROWS; r++) begin
            vchk_o = vchk_o ^ data_i[r*VCHK_W +: VCHK_W];
        end
    end

endmodule

// File: rtl/dmc_syndrome.sv
`timescale 1ns/1ps
// Module dmc_syndrome
// Splits a stored codeword into data, stored sums and stored column checks.
// It re-encodes the data with dmc_encoder, then forms per-pair integer
// differences and the column XOR syndrome.
// Assumes the layout {vertical, horizontal, data}, data in the low bits.
module dmc_syndrome #(
    parameter  int unsigned SYM_W  = dmc_pkg::SYM_W,
    parameter  int unsigned ROWS   = dmc_pkg::ROWS,
    parameter  int unsigned COLS   = dmc_pkg::COLS,
    localparam int unsigned DATA_W = SYM_W * ROWS * COLS,
    localparam int unsigned NPAIR  = ROWS * (COLS / 2),
    localparam int unsigned HSUM_W = SYM_W + 1,
    localparam int unsigned HCHK_W = NPAIR * HSUM_W,
    localparam int unsigned VCHK_W = COLS * SYM_W,
    localparam int unsigned CW_W   = DATA_W + HCHK_W + VCHK_W
) (
    input  logic [CW_W-1:0]   cw_i,
    output logic [NPAIR-1:0]  pair_hit_o,
    output logic [VCHK_W-1:0] vsyn_o,
    output logic              any_err_o
);

    logic [HCHK_W-1:0] h_re;
    logic [VCHK_W-1:0] v_re;

    // Recompute the checks with the shared encoder.
    dmc_encoder #(
        .SYM_W (SYM_W),
        .ROWS  (ROWS),
        .COLS  (COLS)
    ) u_reenc (
        .data_i (cw_i[DATA_W-1:0]),
        .hchk_o (h_re),
        .vchk_o (v_re)
    );

    // Integer difference per pair; any non-zero bit marks the pair.
    for (genvar p = 0; p < NPAIR; p++) begin : g_hsyn
        logic [HSUM_W-1:0] diff;
        assign diff          = h_re[p*HSUM_W +: HSUM_W] - cw_i[DATA_W + p*HSUM_W +: HSUM_W];
        assign pair_hit_o[p] = |diff;
    end

    // Column syndrome and overall detection.
    assign vsyn_o    = v_re ^ cw_i[DATA_W + HCHK_W +: VCHK_W];
    assign any_err_o = (|pair_hit_o) | (|vsyn_o);

endmodule

// File: rtl/dmc_corrector.sv
`timescale 1ns/1ps
// Module dmc_corrector
// Inverts each data bit whose column syndrome is set and whose pair is marked.
// It also reports whether any bit was inverted.
// Assumes pair_hit_i and vsyn_i come from dmc_syndrome for the same data.
module dmc_corrector #(
    parameter  int unsigned SYM_W  = dmc_pkg::SYM_W,
    parameter  int unsigned ROWS   = dmc_pkg::ROWS,
    parameter  int unsigned COLS   = dmc_pkg::COLS,
    localparam int unsigned DATA_W = SYM_W * ROWS * COLS,
    localparam int unsigned NPAIR  = ROWS * (COLS / 2),
    localparam int unsigned VCHK_W = COLS * SYM_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [NPAIR-1:0]  pair_hit_i,
    input  logic [VCHK_W-1:0] vsyn_i,
    output logic [DATA_W-1:0] data_o,
    output logic              flipped_o
);

    logic [DATA_W-1:0] flip;

    // Flip mask: column flag AND owning-pair flag, bit by bit.
    for (genvar n = 0; n < DATA_W; n++) begin : g_bit
        localparam int unsigned PI = dmc_pkg::pair_of_bit(n, SYM_W, COLS);
        localparam int unsigned CI = n % VCHK_W;
        assign flip[n] = vsyn_i[CI] & pair_hit_i[PI];
    end

    assign data_o    = data_i ^ flip;
    assign flipped_o = |flip;

endmodule

// File: rtl/dmc_decoder.sv
`timescale 1ns/1ps
// Module dmc_decoder (top)
// Single-stage decimal matrix code decoder. The syndrome and correction logic
// are combinational from cw_i, and the results are registered on a strobe.
// Assumes one codeword per strobe and a synchronous active-low reset.
module dmc_decoder #(
    parameter  int unsigned SYM_W  = dmc_pkg::SYM_W,
    parameter  int unsigned ROWS   = dmc_pkg::ROWS,
    parameter  int unsigned COLS   = dmc_pkg::COLS,
    localparam int unsigned DATA_W = SYM_W * ROWS * COLS,
    localparam int unsigned NPAIR  = ROWS * (COLS / 2),
    localparam int unsigned HCHK_W = NPAIR * (SYM_W + 1),
    localparam int unsigned VCHK_W = COLS * SYM_W,
    localparam int unsigned CW_W   = DATA_W + HCHK_W + VCHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_valid_i,
    input  logic [CW_W-1:0]   cw_i,
    output logic              data_valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              err_detected_o,
    output logic              err_corrected_o
);

    logic [NPAIR-1:0]  pair_hit;
    logic [VCHK_W-1:0] vsyn;
    logic              any_err;
    logic [DATA_W-1:0] fixed;
    logic              any_flip;

    dmc_syndrome #(
        .SYM_W (SYM_W),
        .ROWS  (ROWS),
        .COLS  (COLS)
    ) u_syn (
        .cw_i       (cw_i),
        .pair_hit_o (pair_hit),
        .vsyn_o     (vsyn),
        .any_err_o  (any_err)
    );

    dmc_corrector #(
        .SYM_W (SYM_W),
        .ROWS  (ROWS),
        .COLS  (COLS)
    ) u_fix (
        .data_i     (cw_i[DATA_W-1:0]),
        .pair_hit_i (pair_hit),
        .vsyn_i     (vsyn),
        .data_o     (fixed),
        .flipped_o  (any_flip)
    );

    // Output register: strobe every cycle, payload and flags only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_valid_o    <= 1'b0;
            data_o          <= '0;
            err_detected_o  <= 1'b0;
            err_corrected_o <= 1'b0;
        end else begin
            data_valid_o <= cw_valid_i;
            if (cw_valid_i) begin
                data_o          <= fixed;
                err_detected_o  <= any_err;
                err_corrected_o <= any_flip;
            end
        end
    end

endmodule

// File: rtl/dmc_decoder_chk.sv
`timescale 1ns/1ps
// Module dmc_decoder_chk
// Temporal properties of dmc_decoder, bound into every instance of it.
// Assumes the internal syndrome signals pair_hit and vsyn of the top.
module dmc_decoder_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NPAIR  = 4,
    parameter int unsigned VCHK_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cw_valid_i,
    input logic [DATA_W-1:0] cw_data,
    input logic              data_valid_o,
    input logic [DATA_W-1:0] data_o,
    input logic              err_detected_o,
    input logic              err_corrected_o,
    input logic [NPAIR-1:0]  pair_hit,
    input logic [VCHK_W-1:0] vsyn
);

    p_strobe_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid_i |=> data_valid_o);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cw_valid_i |=> !data_valid_o);

    p_reset_clears_r2: assert property (@(posedge clk)
        !rst_n |=> (!data_valid_o && !err_detected_o && !err_corrected_o && data_o == '0));

    p_clean_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid_i && pair_hit == '0 && vsyn == '0) |=> (data_o == $past(cw_data) && !err_detected_o));

    p_no_pair_no_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid_i && pair_hit == '0) |=> (data_o == $past(cw_data) && !err_corrected_o));

    p_detect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid_i && (pair_hit != '0 || vsyn != '0)) |=> err_detected_o);

    p_corr_implies_det_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_corrected_o |-> err_detected_o);

    p_change_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid_o && data_o != $past(cw_data)) |-> err_corrected_o);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cw_valid_i |=> ($stable(data_o) && $stable(err_detected_o) && $stable(err_corrected_o)));

endmodule

bind dmc_decoder dmc_decoder_chk #(
    .DATA_W (DATA_W),
    .NPAIR  (NPAIR),
    .VCHK_W (VCHK_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cw_valid_i      (cw_valid_i),
    .cw_data         (cw_i[DATA_W-1:0]),
    .data_valid_o    (data_valid_o),
    .data_o          (data_o),
    .err_detected_o  (err_detected_o),
    .err_corrected_o (err_corrected_o),
    .pair_hit        (pair_hit),
    .vsyn            (vsyn)
);

// File: tb/dmc_decoder_tb.sv
`timescale 1ns/1ps
// Bench for dmc_decoder: reset, clean words, every burst of 1..5 bits at
// every position over several data patterns, and the listed corner cases.
module dmc_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cw_valid_i;
    logic [67:0] cw_i;
    logic        data_valid_o;
    logic [31:0] data_o;
    logic        err_detected_o;
    logic        err_corrected_o;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dmc_decoder u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cw_valid_i      (cw_valid_i),
        .cw_i            (cw_i),
        .data_valid_o    (data_valid_o),
        .data_o          (data_o),
        .err_detected_o  (err_detected_o),
        .err_corrected_o (err_corrected_o)
    );

    // Reference encoder written from the R4 layout.
    function automatic logic [67:0] enc(input logic [31:0] d);
        logic [19:0] h;
        logic [15:0] v;
        for (int p = 0; p < 4; p++) begin
            int a;
            a = (p / 2) * 4 + (p % 2);
            h[p*5 +: 5] = {1'b0, d[a*4 +: 4]} + {1'b0, d[(a+2)*4 +: 4]};
        end
        v = d[15:0] ^ d[31:16];
        return {v, h, d};
    endfunction

    // Compare one result against its expectation and count the vector.
    task automatic judge(input string tag, input logic [31:0] exp_d,
                         input logic exp_det, input logic exp_cor, input logic exp_vld);
        n_vec++;
        if (data_o !== exp_d || err_detected_o !== exp_det ||
            err_corrected_o !== exp_cor || data_valid_o !== exp_vld) begin
            n_bad++;
            $display("FAIL %s: got data=%h det=%b cor=%b vld=%b, expected data=%h det=%b cor=%b vld=%b",
                     tag, data_o, err_detected_o, err_corrected_o, data_valid_o,
                     exp_d, exp_det, exp_cor, exp_vld);
        end
    endtask

    // Drive one codeword for one cycle and check the result one cycle later (R1).
    task automatic run_vec(input logic [67:0] cw, input logic [31:0] exp_d,
                           input logic exp_det, input logic exp_cor, input string tag);
        @(negedge clk);
        cw_i       = cw;
        cw_valid_i = 1'b1;
        @(negedge clk);
        cw_valid_i = 1'b0;
        judge(tag, exp_d, exp_det, exp_cor, 1'b1);
    endtask

    logic [31:0] words [7] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A,
                               32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_F0F0,
                               32'h8000_0001};

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R2: reset held low while a strobe and a codeword are driven.
        rst_n      = 1'b0;
        cw_valid_i = 1'b1;
        cw_i       = enc(32'hCAFE_F00D) ^ 68'h1;
        repeat (3) @(negedge clk);
        judge("R2 reset", 32'h0, 1'b0, 1'b0, 1'b0);
        rst_n      = 1'b1;
        cw_valid_i = 1'b0;

        // R3 R4: clean words pass unchanged with both flags low.
        for (int w = 0; w < 7; w++) begin
            run_vec(enc(words[w]), words[w], 1'b0, 1'b0, "R3 R4 clean");
        end

        // R7 R8 R9: every burst of 1..5 adjacent bits at every start.
        for (int w = 0; w < 7; w++) begin
            for (int pos = 0; pos < 68; pos++) begin
                for (int len = 1; len <= 5; len++) begin
                    if (pos + len <= 68) begin
                        logic [67:0] m;
                        m = '0;
                        for (int k = 0; k < len; k++) m[pos+k] = 1'b1;
                        run_vec(enc(words[w]) ^ m, words[w], 1'b1, (pos < 32),
                                $sformatf("%s burst pos=%0d len=%0d word=%h",
                                          (pos < 32) ? "R7 R8" : "R9 R8 check-only",
                                          pos, len, words[w]));
                    end
                end
            end
        end

        // R5 R6: data s0=15, s2=7 sums to 22; stored sum forced to 18.
        begin
            logic [67:0] cw;
            cw = enc(32'h0000_070F);
            cw[36:32] = 5'd18;
            run_vec(cw, 32'h0000_070F, 1'b1, 1'b0, "R5 R6 pair-only mismatch");
        end

        // R10: swap 0110 and 1001 between s0 and s2; the sum stays 15.
        begin
            logic [67:0] cw;
            logic [31:0] bad;
            cw  = enc(32'h1234_0906);
            bad = 32'h1234_0609;
            cw[31:0] = bad;
            run_vec(cw, bad, 1'b1, 1'b0, "R10 sum-preserving swap");
        end

        // R11 R1: after a corrected word, an idle cycle with new input changes nothing.
        run_vec(enc(32'h1357_9BDF) ^ (68'h3 << 5), 32'h1357_9BDF, 1'b1, 1'b1, "R11 setup");
        @(negedge clk);
        cw_i       = enc(32'h0);
        cw_valid_i = 1'b0;
        @(negedge clk);
        judge("R11 R1 idle hold", 32'h1357_9BDF, 1'b1, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule